// File: doc/BRIEF.md
# Ingress Rate Policer

This block meters the traffic arriving on one switch port. Each priority level has its own token bucket, which holds byte credit. A periodic timebase tick refills the bucket at a rate taken from a coded setting. When a frame starts, the policer tells the receive path whether to keep the frame or drop it. When an accepted frame ends, its byte length is charged against the bucket of its priority.

The rate code has two ranges. The low range steps in 64 kbit/s units and the high range steps in 1 Mbit/s units. Some codes mean no limit at all. In 10 Mbit/s link mode, any rate above the line rate also means no limit. The counted length can be padded with preamble bytes, inter-frame-gap bytes, or both. A class selector limits metering to one frame class, or applies it to every class. Frames that are not metered pass through untouched and cost nothing.

Top module: `ingress_policer`

## Requirements
- R1: A rate code from 1 to 15 means code×64 kbit/s. Each tick then adds code×STEP_LO bytes (STEP_LO=8) to that priority's credit.
- R2: A rate code from 16 to 115 means (code−15) Mbit/s. Each tick then adds (code−15)×STEP_HI bytes (STEP_HI=125).
- R3: Rate code 0 and rate codes above 115 mean no limit. Frames at that priority are never dropped and never charged.
- R4: When link_10m is 1, rate codes 26 to 115 (above 10 Mbit/s) also mean no limit.
- R5: Each of the NPRI priorities has its own credit. Refills and charges on one priority leave every other priority unchanged.
- R6: Credit starts at MAX_BURST (1536) after reset. After a refill, credit is capped at MAX_BURST.
- R7: drop_valid is 1 exactly one cycle after a cycle with sof_valid=1. In that cycle, drop is 1 only when the frame is metered and its priority's credit was ≤ 0 when sof_valid was sampled.
- R8: At eof_valid, an accepted metered frame subtracts eof_len plus the padding selected by len_mode: 0 adds 0, 1 adds 8 (preamble), 2 adds 12 (gap), 3 adds 20. Credit may go negative. Dropped frames are not charged.
- R9: class_sel=0 meters every frame. class_sel values 1, 2 and 3 meter only frames whose sof_class has the same value. The sof_class codes are 0 = known unicast, 1 = multicast, 2 = broadcast, 3 = flooded unknown unicast.
- R10: A frame outside the selected class is never dropped and is never charged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe that triggers a refill |
| link_10m | input | 1 | Port is running at 10 Mbit/s |
| rate_code | input | NPRI*7 | Coded rate, 7 bits per priority (priority p in bits 7p+6:7p) |
| len_mode | input | 2 | Padding added to the counted length |
| class_sel | input | 2 | Frame class to meter (0 meters all classes) |
| sof_valid | input | 1 | Start-of-frame strobe |
| sof_pri | input | $clog2(NPRI) | Priority of the starting frame |
| sof_class | input | 2 | Class of the starting frame |
| eof_valid | input | 1 | End-of-frame strobe |
| eof_len | input | LENW | Frame length in bytes, from destination address to FCS |
| drop_valid | output | 1 | A drop decision is present |
| drop | output | 1 | The frame must be dropped |

## Verification
The drop decision is registered. It appears one cycle after the start-of-frame strobe, so the bench drives each stimulus at a falling edge and samples drop_valid and drop shortly after the next rising edge. Refills and end-of-frame charges take effect at the same rising edge that samples them. The bench's credit model therefore updates at that edge, and the next start-of-frame decision uses the new value. Every start-of-frame check compares against a decision computed from that model, and cycles without a start-of-frame check that drop_valid stays low.

// File: rtl/ingress_policer.sv
module ingress_policer #(
  parameter int NPRI      = 4,
  parameter int LENW      = 11,
  parameter int CW        = 16,
  parameter int STEP_LO   = 8,
  parameter int STEP_HI   = 125,
  parameter int MAX_BURST = 1536
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      link_10m,
  input  logic [NPRI*7-1:0]         rate_code,
  input  logic [1:0]                len_mode,
  input  logic [1:0]                class_sel,
  input  logic                      sof_valid,
  input  logic [$clog2(NPRI)-1:0]   sof_pri,
  input  logic [1:0]                sof_class,
  input  logic                      eof_valid,
  input  logic [LENW-1:0]           eof_len,
  output logic                      drop_valid,
  output logic                      drop
);
  localparam int PW = $clog2(NPRI);
  localparam int SW = CW + 1;
  localparam logic signed [SW-1:0] CAP = SW'(MAX_BURST);

  logic signed [CW-1:0] credit [NPRI];
  logic [NPRI-1:0]      unl;
  logic [CW-1:0]        fill [NPRI];
  logic                 charge_q;
  logic [PW-1:0]        charge_pri;
  logic [4:0]           pad;
  logic [LENW:0]        charged;
  logic                 class_hit, metered, deny;

  always_comb begin
    case (len_mode)
      2'd0:    pad = 5'd0;
      2'd1:    pad = 5'd8;
      2'd2:    pad = 5'd12;
      default: pad = 5'd20;
    endcase
  end

  assign charged   = (LENW+1)'(eof_len) + (LENW+1)'(pad);
  assign class_hit = (class_sel == 2'd0) || (sof_class == class_sel);
  assign metered   = sof_valid && class_hit && !unl[sof_pri];
  assign deny      = metered && (credit[sof_pri] <= 0);

  for (genvar g = 0; g < NPRI; g++) begin : g_pri
    logic [6:0]           code;
    logic signed [SW-1:0] nxt;
    assign code   = rate_code[g*7 +: 7];
    assign unl[g] = (code == 7'd0) || (code > 7'd115) || (link_10m && code > 7'd25);
    assign fill[g] = unl[g] ? '0 :
                     (code < 7'd16) ? CW'(code) * CW'(STEP_LO)
                                    : CW'(code - 7'd15) * CW'(STEP_HI);
    always_comb begin
      nxt = {credit[g][CW-1], credit[g]};
      if (tick) nxt = nxt + $signed({1'b0, fill[g]});
      if (eof_valid && charge_q && charge_pri == PW'(g))
        nxt = nxt - $signed(SW'(charged));
      if (nxt > CAP) nxt = CAP;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) credit[g] <= CW'(MAX_BURST);
      else        credit[g] <= CW'(nxt);
    end

    a_r6_cap: assert property (@(posedge clk) disable iff (!rst_n)
      credit[g] <= $signed(CW'(MAX_BURST)));
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !(eof_valid && charge_q && charge_pri == PW'(g)) |=> $stable(credit[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_valid <= 1'b0;
      drop       <= 1'b0;
      charge_q   <= 1'b0;
      charge_pri <= '0;
    end else begin
      drop_valid <= sof_valid;
      drop       <= deny;
      if (sof_valid) begin
        charge_q   <= metered && !deny;
        charge_pri <= sof_pri;
      end else if (eof_valid) begin
        charge_q <= 1'b0;
      end
    end
  end

  a_r7_decision_follows_sof: assert property (@(posedge clk) disable iff (!rst_n)
    sof_valid |=> drop_valid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_valid |=> !drop_valid && !drop);
  a_r10_unmetered_pass: assert property (@(posedge clk) disable iff (!rst_n)
    sof_valid && !class_hit |=> !drop);
  a_r3_unlimited_pass: assert property (@(posedge clk) disable iff (!rst_n)
    sof_valid && unl[sof_pri] |=> !drop);
  a_r8_dropped_not_charged: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid && drop |-> !charge_q);
endmodule

// File: tb/sim_ingress_policer.sv
module sim_ingress_policer;
  localparam int NPRI = 4, LENW = 11, MAXB = 1536;
  logic clk = 0, rst_n = 0, tick = 0, link_10m = 0;
  logic [NPRI*7-1:0] rate_code = '0;
  logic [1:0] len_mode = 0, class_sel = 0, sof_class = 0;
  logic sof_valid = 0, eof_valid = 0;
  logic [1:0] sof_pri = 0;
  logic [LENW-1:0] eof_len = 0;
  logic drop_valid, drop;

  ingress_policer u0 (.clk, .rst_n, .tick, .link_10m, .rate_code, .len_mode, .class_sel,
    .sof_valid, .sof_pri, .sof_class, .eof_valid, .eof_len, .drop_valid, .drop);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int cred [NPRI];
  bit chg_q = 0;
  int chg_p = 0;

  task automatic chk(string r, int got, int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", r, got, exp, $time);
    end
  endtask

  function automatic int code_of(int p);
    return int'(rate_code[p*7 +: 7]);
  endfunction
  function automatic bit unl(int p);
    int c = code_of(p);
    return c == 0 || c > 115 || (link_10m && c > 25);
  endfunction
  function automatic int fill(int p);
    int c = code_of(p);
    if (unl(p)) return 0;
    return (c < 16) ? c * 8 : (c - 15) * 125;
  endfunction
  function automatic int padb();
    case (len_mode) 0: return 0; 1: return 8; 2: return 12; default: return 20; endcase
  endfunction

  task automatic cyc(string r, bit tk, bit sv, int sp, int sc, bit ev, int el);
    bit met, ed;
    @(negedge clk);
    tick = tk; sof_valid = sv; sof_pri = 2'(sp); sof_class = 2'(sc);
    eof_valid = ev; eof_len = LENW'(el);
    met = sv && (class_sel == 0 || sc == int'(class_sel)) && !unl(sp);
    ed  = met && cred[sp] <= 0;
    for (int p = 0; p < NPRI; p++) begin
      int n = cred[p];
      if (tk) n += fill(p);
      if (ev && chg_q && chg_p == p) n -= el + padb();
      if (n > MAXB) n = MAXB;
      cred[p] = n;
    end
    if (sv) begin chg_q = met && !ed; chg_p = sp; end
    else if (ev) chg_q = 0;
    @(posedge clk); #2;
    chk({r, " valid"}, int'(drop_valid), int'(sv));
    if (sv) chk({r, " drop"}, int'(drop), int'(ed));
  endtask

  task automatic frame(string r, int p, int c, int len);
    cyc(r, 0, 1, p, c, 0, 0);
    cyc(r, 0, 0, 0, 0, 1, len);
  endtask

  task automatic set_code(int p, int c);
    rate_code[p*7 +: 7] = 7'(c);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < NPRI; p++) cred[p] = MAXB;
    set_code(0, 1); set_code(1, 20); set_code(2, 0); set_code(3, 200);
    repeat (3) @(posedge clk);
    #2;
    chk("R7 reset valid", int'(drop_valid), 0);
    chk("R7 reset drop", int'(drop), 0);
    @(negedge clk); rst_n = 1;

    frame("R6 full bucket", 0, 0, 1000);
    frame("R8 overdraft", 0, 0, 1000);
    frame("R7 exhausted", 0, 0, 100);
    frame("R5 other pri", 1, 0, 500);
    repeat (58) cyc("R1 refill", 1, 0, 0, 0, 0, 0);
    frame("R1 at zero", 0, 0, 64);
    cyc("R1 refill", 1, 0, 0, 0, 0, 0);
    frame("R1 positive", 0, 0, 64);

    for (int i = 0; i < 4; i++) frame("R3 code0", 2, 0, 2000);
    for (int i = 0; i < 4; i++) frame("R3 code200", 3, 0, 2000);

    for (int i = 0; i < 4; i++) frame("R2 drain", 1, 0, 1500);
    cyc("R2 refill", 1, 0, 0, 0, 0, 0);
    frame("R2 after tick", 1, 0, 100);

    link_10m = 1; set_code(1, 30);
    for (int i = 0; i < 4; i++) frame("R4 above line", 1, 0, 2000);
    set_code(1, 25);
    for (int i = 0; i < 4; i++) frame("R4 at line", 1, 0, 2000);
    link_10m = 0; set_code(1, 115);

    repeat (3) cyc("R6 cap", 1, 0, 0, 0, 0, 0);
    len_mode = 2;
    frame("R8 pad gap", 1, 0, 1524);
    frame("R8 zero credit", 1, 0, 10);
    repeat (3) cyc("R6 cap", 1, 0, 0, 0, 0, 0);
    len_mode = 0;
    frame("R8 no pad", 1, 0, 1523);
    frame("R8 small credit", 1, 0, 10);

    class_sel = 2;
    set_code(0, 1);
    for (int i = 0; i < 3; i++) frame("R9 broadcast", 0, 2, 1000);
    frame("R10 multicast bypass", 0, 1, 1000);
    frame("R10 unicast bypass", 0, 0, 1000);
    frame("R9 broadcast still", 0, 2, 100);
    class_sel = 0;

    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        for (int p = 0; p < NPRI; p++) set_code(p, int'($urandom_range(0, 127)));
        link_10m  = 1'($urandom_range(0, 1));
        len_mode  = 2'($urandom_range(0, 3));
        class_sel = 2'($urandom_range(0, 3));
      end
      cyc("R7 random", 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 2) == 0),
          int'($urandom_range(0, NPRI-1)), int'($urandom_range(0, 3)),
          1'($urandom_range(0, 2) == 0), int'($urandom_range(64, 1518)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule